// File: doc/BRIEF.md
# DMA Channel Request Generator

This block produces the transfer-request strobes for a four-channel DMA controller. A 4-bit source-select code on each channel picks where the request comes from. The request can be raised internally and continuously (auto mode), taken from an external request pin, or taken from one of a set of on-chip peripheral request lines. The same code also tells the transfer engine whether the channel moves data with one bus address or two. For one-address transfers it also gives the direction: from the external device to memory, or from memory to the device. Whatever raises a request need not be the source or the destination of the data.

A channel may request only while it is qualified. Its own enable must be set and the global master enable must be set. Its transfer-end flag, its address-error flag and the global non-maskable-interrupt flag must all be clear. External pins exist only on the low-numbered channels, two by default. Each pin first passes through a two-flop synchronizer. It is then sensed either by level or by edge, and a per-pin polarity bit chooses between low level or falling edge and high level or rising edge. A grant from the arbiter consumes the request that is pending. A captured edge stays pending until it is granted or until the channel loses its qualification.

Top module: `dma_req_gen`

## Requirements
- R1: `req_valid[c]` is 0 in the cycle after any cycle where the channel is not qualified: `ch_en[c]`=0, `master_en`=0, `ch_tend[c]`=1, `ch_aerr[c]`=1 or `nmi_flag`=1. Losing qualification also discards a captured edge.
- R2: Select code 4'b0100 (auto) sets `req_valid[c]` one cycle after any cycle where the channel is qualified and `grant[c]` is 0.
- R3: The external codes 4'b0000, 4'b0010 and 4'b0011 never raise a request on channels at or above NUM_EXT (2 and 3 by default).
- R4: Code 4'b0000 on an external-capable channel gives a dual-address transfer: `addr_single`=0 and `to_device`=0.
- R5: Code 4'b0010 gives `addr_single`=1 and `to_device`=0, meaning device to memory. Code 4'b0011 gives `addr_single`=1 and `to_device`=1, meaning memory to device. Auto and peripheral codes report `addr_single`=0 and `to_device`=0.
- R6: In level mode (`ext_edge_mode`=0), a change on an external pin reaches `req_valid` at the third rising clock edge after it is applied.
- R7: In edge mode (`ext_edge_mode`=1), a detected edge is held in `req_valid` until `grant[c]` arrives. This holds even after the pin returns to its idle level.
- R8: A cycle with `grant[c]`=1 makes `req_valid[c]` 0 in the next cycle, unless a new edge is detected in that same cycle. The request is then re-evaluated from its source.
- R9: Codes 4'b10xx copy peripheral line `periph_req[xx]` into `req_valid` one cycle later.
- R10: Codes 4'b0001, 4'b0101 to 4'b0111 and 4'b11xx, and external codes on channels without a pin, set `cfg_err[c]`=1 and raise no request. Legal codes give `cfg_err[c]`=0.
- R11: With `ext_pol`=0 the active sense is low level or falling edge. With `ext_pol`=1 it is high level or rising edge.
- R12: While `rst` is high, every output is 0 after each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | Global DMA enable |
| nmi_flag | input | 1 | Global non-maskable-interrupt flag, blocks all channels |
| ch_en | input | NUM_CH | Per-channel enable |
| ch_tend | input | NUM_CH | Per-channel transfer-end flag |
| ch_aerr | input | NUM_CH | Per-channel address-error flag |
| ch_sel | input | NUM_CH*4 | Source-select codes, channel c at bits [4c+3:4c] |
| ext_pin | input | NUM_EXT | Asynchronous external request pins |
| ext_edge_mode | input | NUM_EXT | 1 = edge sensing, 0 = level sensing |
| ext_pol | input | NUM_EXT | 0 = low/falling active, 1 = high/rising active |
| periph_req | input | PERIPH_N | On-chip peripheral request lines |
| grant | input | NUM_CH | Arbiter grant, consumes the pending request |
| req_valid | output | NUM_CH | Registered request per channel |
| addr_single | output | NUM_CH | 1 = single-address transfer |
| to_device | output | NUM_CH | Single-address direction, 1 = memory to device |
| cfg_err | output | NUM_CH | Select code illegal for this channel |

## Verification
Every registered output follows a change in select code, enables, peripheral lines or grant at the next rising edge. An external pin takes three edges: two synchronizer stages and then the request register. The bench drives all inputs at the falling edge and moves forward a whole number of rising edges before it samples, again at a falling edge. Sweep checks wait four edges after each code change so that every output has settled. The latency checks sample at exactly the second and third edges after the pin changes, which proves the request is not early and not late.

// File: rtl/dma_req_pkg.sv
package dma_req_pkg;
  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_EXT    = 2'd1,
    SRC_AUTO   = 2'd2,
    SRC_PERIPH = 2'd3
  } src_e;

  typedef struct packed {
    src_e       src;
    logic       single;
    logic       to_dev;
    logic       bad;
    logic [1:0] pidx;
  } chan_cfg_t;

  localparam logic [SEL_W-1:0] CODE_EXT_DUAL = 4'b0000;
  localparam logic [SEL_W-1:0] CODE_EXT_D2M  = 4'b0010;
  localparam logic [SEL_W-1:0] CODE_EXT_M2D  = 4'b0011;
  localparam logic [SEL_W-1:0] CODE_AUTO     = 4'b0100;

  function automatic logic is_ext_code(input logic [SEL_W-1:0] sel);
    return (sel == CODE_EXT_DUAL) || (sel == CODE_EXT_D2M) || (sel == CODE_EXT_M2D);
  endfunction

  // Decode one select code; ext_ok tells whether the channel owns a pin.
  function automatic chan_cfg_t decode_sel(input logic [SEL_W-1:0] sel,
                                           input logic ext_ok,
                                           input int n_periph);
    chan_cfg_t c;
    c.src    = SRC_NONE;
    c.single = 1'b0;
    c.to_dev = 1'b0;
    c.bad    = 1'b1;
    c.pidx   = sel[1:0];
    if (is_ext_code(sel) && ext_ok) begin
      c.src    = SRC_EXT;
      c.bad    = 1'b0;
      c.single = (sel != CODE_EXT_DUAL);
      c.to_dev = (sel == CODE_EXT_M2D);
    end else if (sel == CODE_AUTO) begin
      c.src = SRC_AUTO;
      c.bad = 1'b0;
    end else if (sel[3:2] == 2'b10 && int'(sel[1:0]) < n_periph) begin
      c.src = SRC_PERIPH;
      c.bad = 1'b0;
    end
    return c;
  endfunction
endpackage

// File: rtl/dma_req_gate.sv
module dma_req_gate #(
  parameter int NUM_CH = 4
) (
  input  logic              master_en,
  input  logic              nmi_flag,
  input  logic [NUM_CH-1:0] ch_en,
  input  logic [NUM_CH-1:0] ch_tend,
  input  logic [NUM_CH-1:0] ch_aerr,
  output logic [NUM_CH-1:0] qual
);
  localparam logic [NUM_CH-1:0] ALL_ONE = '1;
  logic [NUM_CH-1:0] glob_mask;

  always_comb begin
    glob_mask = (master_en && !nmi_flag) ? ALL_ONE : '0;
    qual      = glob_mask & ch_en & ~ch_tend & ~ch_aerr;
  end
endmodule

// File: rtl/dma_req_sync.sv
module dma_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic pol,
  output logic active,
  output logic edge_hit
);
  localparam int LAST = STAGES;

  // sh[STAGES-1] is the synchronized value, sh[STAGES] its previous sample
  logic [LAST:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '1;
    else     sh <= {sh[LAST-1:0], pin};
  end

  logic now_act, was_act;
  always_comb begin
    now_act  = pol ? sh[LAST-1] : ~sh[LAST-1];
    was_act  = pol ? sh[LAST]   : ~sh[LAST];
    active   = now_act;
    edge_hit = now_act & ~was_act;
  end
endmodule

// File: rtl/dma_req_chan.sv
module dma_req_chan
  import dma_req_pkg::*;
#(
  parameter bit HAS_EXT  = 1'b1,
  parameter int PERIPH_N = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SEL_W-1:0]    sel,
  input  logic                qual,
  input  logic                grant,
  input  logic                ext_act,
  input  logic                ext_edge,
  input  logic                ext_emode,
  input  logic [PERIPH_N-1:0] periph_req,
  output logic                req,
  output logic                single,
  output logic                to_dev,
  output logic                bad
);
  localparam int PAD_W = 4;

  chan_cfg_t        cfg;
  logic [PAD_W-1:0] periph_pad;
  logic             want;
  logic             req_q, single_q, to_dev_q, bad_q;

  always_comb begin
    cfg        = decode_sel(sel, HAS_EXT, PERIPH_N);
    periph_pad = '0;
    periph_pad[PERIPH_N-1:0] = periph_req;
    case (cfg.src)
      SRC_AUTO:   want = ~grant;
      SRC_EXT:    want = ext_emode ? (ext_edge | (req_q & ~grant))
                                   : (ext_act & ~grant);
      SRC_PERIPH: want = periph_pad[cfg.pidx] & ~grant;
      default:    want = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q    <= 1'b0;
      single_q <= 1'b0;
      to_dev_q <= 1'b0;
      bad_q    <= 1'b0;
    end else begin
      req_q    <= qual & want;
      single_q <= cfg.single;
      to_dev_q <= cfg.to_dev;
      bad_q    <= cfg.bad;
    end
  end

  assign req    = req_q;
  assign single = single_q;
  assign to_dev = to_dev_q;
  assign bad    = bad_q;

  // R7: a captured edge survives while qualified and not granted
  a_r7_edge_hold: assert property (@(posedge clk) disable iff (rst)
    (cfg.src == SRC_EXT && ext_emode && req_q && !grant && qual) |=> req_q);

  // R8: a grant consumes the request unless a fresh edge arrives
  a_r8_grant_consumes: assert property (@(posedge clk) disable iff (rst)
    (grant && !(cfg.src == SRC_EXT && ext_emode && ext_edge)) |=> !req_q);

  // R10: an illegal configuration never carries a request
  a_r10_bad_silent: assert property (@(posedge clk) disable iff (rst)
    bad_q |-> !req_q);
endmodule

// File: rtl/dma_req_gen.sv
module dma_req_gen
  import dma_req_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int NUM_EXT  = 2,
  parameter int PERIPH_N = 4,
  parameter int STAGES   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    master_en,
  input  logic                    nmi_flag,
  input  logic [NUM_CH-1:0]       ch_en,
  input  logic [NUM_CH-1:0]       ch_tend,
  input  logic [NUM_CH-1:0]       ch_aerr,
  input  logic [NUM_CH*SEL_W-1:0] ch_sel,
  input  logic [NUM_EXT-1:0]      ext_pin,
  input  logic [NUM_EXT-1:0]      ext_edge_mode,
  input  logic [NUM_EXT-1:0]      ext_pol,
  input  logic [PERIPH_N-1:0]     periph_req,
  input  logic [NUM_CH-1:0]       grant,
  output logic [NUM_CH-1:0]       req_valid,
  output logic [NUM_CH-1:0]       addr_single,
  output logic [NUM_CH-1:0]       to_device,
  output logic [NUM_CH-1:0]       cfg_err
);
  logic [NUM_CH-1:0] qual;
  logic [NUM_CH-1:0] ext_act, ext_edge, ext_emode;

  dma_req_gate #(.NUM_CH(NUM_CH)) u_gate (
    .master_en (master_en),
    .nmi_flag  (nmi_flag),
    .ch_en     (ch_en),
    .ch_tend   (ch_tend),
    .ch_aerr   (ch_aerr),
    .qual      (qual)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (c < NUM_EXT) begin : g_ext
      dma_req_sync #(.STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin      (ext_pin[c]),
        .pol      (ext_pol[c]),
        .active   (ext_act[c]),
        .edge_hit (ext_edge[c])
      );
      assign ext_emode[c] = ext_edge_mode[c];
    end else begin : g_noext
      assign ext_act[c]   = 1'b0;
      assign ext_edge[c]  = 1'b0;
      assign ext_emode[c] = 1'b0;

      // R3: no pin, so external codes never request
      a_r3_no_pin_req: assert property (@(posedge clk) disable iff (rst)
        is_ext_code(ch_sel[c*SEL_W +: SEL_W]) |=> !req_valid[c]);
    end

    dma_req_chan #(.HAS_EXT(c < NUM_EXT), .PERIPH_N(PERIPH_N)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .sel        (ch_sel[c*SEL_W +: SEL_W]),
      .qual       (qual[c]),
      .grant      (grant[c]),
      .ext_act    (ext_act[c]),
      .ext_edge   (ext_edge[c]),
      .ext_emode  (ext_emode[c]),
      .periph_req (periph_req),
      .req        (req_valid[c]),
      .single     (addr_single[c]),
      .to_dev     (to_device[c]),
      .bad        (cfg_err[c])
    );

    // R1: any failed qualifier blocks the next-cycle request
    a_r1_gate: assert property (@(posedge clk) disable iff (rst)
      (!ch_en[c] || !master_en || nmi_flag || ch_tend[c] || ch_aerr[c])
        |=> !req_valid[c]);

    // R2: auto mode requests whenever qualified and not granted
    a_r2_auto: assert property (@(posedge clk) disable iff (rst)
      (ch_sel[c*SEL_W +: SEL_W] == CODE_AUTO && ch_en[c] && master_en && !nmi_flag
        && !ch_tend[c] && !ch_aerr[c] && !grant[c]) |=> req_valid[c]);

    // R5: a single-address mode is flagged only together with a clean code
    a_r5_single_legal: assert property (@(posedge clk) disable iff (rst)
      addr_single[c] |-> !cfg_err[c]);
  end
endmodule

// File: tb/tb_dma_req_gen.sv
module tb_dma_req_gen;
  localparam int NUM_CH = 4;
  localparam int NUM_EXT = 2;
  localparam int PERIPH_N = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, master_en, nmi_flag;
  logic [NUM_CH-1:0] ch_en, ch_tend, ch_aerr, grant;
  logic [NUM_CH*4-1:0] ch_sel;
  logic [NUM_EXT-1:0] ext_pin, ext_edge_mode, ext_pol;
  logic [PERIPH_N-1:0] periph_req;
  logic [NUM_CH-1:0] req_valid, addr_single, to_device, cfg_err;

  int checks = 0;
  int errors = 0;

  dma_req_gen #(.NUM_CH(NUM_CH), .NUM_EXT(NUM_EXT), .PERIPH_N(PERIPH_N)) dut (
    .clk(clk), .rst(rst), .master_en(master_en), .nmi_flag(nmi_flag),
    .ch_en(ch_en), .ch_tend(ch_tend), .ch_aerr(ch_aerr), .ch_sel(ch_sel),
    .ext_pin(ext_pin), .ext_edge_mode(ext_edge_mode), .ext_pol(ext_pol),
    .periph_req(periph_req), .grant(grant), .req_valid(req_valid),
    .addr_single(addr_single), .to_device(to_device), .cfg_err(cfg_err)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic set_all(input logic [3:0] code);
    for (int c = 0; c < NUM_CH; c++) ch_sel[c*4 +: 4] = code;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [3:0] pats [2];
    pats[0] = 4'b0101;
    pats[1] = 4'b1010;

    // R12: reset with everything that would otherwise request
    rst = 1'b1; master_en = 1'b1; nmi_flag = 1'b0;
    ch_en = '1; ch_tend = '0; ch_aerr = '0; grant = '0;
    ext_pin = '0; ext_edge_mode = '0; ext_pol = '0; periph_req = '1;
    set_all(4'b0011);
    step(3);
    for (int c = 0; c < NUM_CH; c++) begin
      check("R12 reset req", req_valid[c], 1'b0);
      check("R12 reset single", addr_single[c], 1'b0);
      check("R12 reset dir", to_device[c], 1'b0);
      check("R12 reset err", cfg_err[c], 1'b0);
    end
    rst = 1'b0;

    // Sweep: every code on every channel under two peripheral patterns
    // (R2 R3 R4 R5 R9 R10); pins held low so level mode is active.
    for (int p = 0; p < 2; p++) begin
      periph_req = pats[p];
      for (int s = 0; s < 16; s++) begin
        set_all(4'(s));
        step(4);
        for (int c = 0; c < NUM_CH; c++) begin
          logic ext, aut, per, err, exp_req;
          ext = (s == 0 || s == 2 || s == 3) && (c < NUM_EXT);
          aut = (s == 4);
          per = (s >= 8 && s <= 11);
          err = !(ext || aut || per);
          exp_req = !err && (ext || aut || (per && pats[p][s % 4]));
          check("R10 R3 cfg_err sweep", cfg_err[c], err);
          check("R2 R3 R9 req sweep", req_valid[c], exp_req);
          check("R4 R5 single sweep", addr_single[c], ext && s != 0);
          check("R5 direction sweep", to_device[c], ext && s == 3);
        end
      end
    end

    // R1: all 32 combinations of the five qualifiers, auto mode
    set_all(4'b0100);
    for (int m = 0; m < 32; m++) begin
      ch_en = {NUM_CH{m[0]}}; master_en = m[1]; ch_tend = {NUM_CH{m[2]}};
      ch_aerr = {NUM_CH{m[3]}}; nmi_flag = m[4];
      step(1);
      for (int c = 0; c < NUM_CH; c++)
        check("R1 qualifier gate", req_valid[c], m[0] && m[1] && !m[2] && !m[3] && !m[4]);
    end
    ch_en = '1; master_en = 1'b1; ch_tend = '0; ch_aerr = '0; nmi_flag = 1'b0;

    // R2 R8: auto request drops for one cycle on grant
    grant[2] = 1'b1;
    step(1);
    check("R8 auto grant drop", req_valid[2], 1'b0);
    grant[2] = 1'b0;
    step(1);
    check("R2 auto reassert", req_valid[2], 1'b1);

    // R6: level mode latency on channel 0
    set_all(4'b1111);
    ch_sel[3:0] = 4'b0000;
    ext_pin = 2'b11;
    step(4);
    check("R6 level idle", req_valid[0], 1'b0);
    ext_pin[0] = 1'b0;
    step(2);
    check("R6 level not early", req_valid[0], 1'b0);
    step(1);
    check("R6 level on time", req_valid[0], 1'b1);
    grant[0] = 1'b1;
    step(1);
    check("R8 level grant drop", req_valid[0], 1'b0);
    grant[0] = 1'b0;
    step(1);
    check("R8 level re-evaluated", req_valid[0], 1'b1);
    ext_pin[0] = 1'b1;
    step(3);
    check("R6 level release", req_valid[0], 1'b0);

    // R11: high-active level on channel 0
    ext_pol[0] = 1'b1;
    ext_pin[0] = 1'b0;
    step(3);
    check("R11 high level idle", req_valid[0], 1'b0);
    ext_pin[0] = 1'b1;
    step(3);
    check("R11 high level active", req_valid[0], 1'b1);
    ext_pol[0] = 1'b0;

    // R7: falling-edge capture on channel 1, single address device to memory
    ch_sel[7:4] = 4'b0010;
    ext_edge_mode[1] = 1'b1;
    ext_pin[1] = 1'b1;
    step(4);
    check("R7 edge idle", req_valid[1], 1'b0);
    ext_pin[1] = 1'b0;
    step(3);
    check("R7 edge captured", req_valid[1], 1'b1);
    ext_pin[1] = 1'b1;
    step(5);
    check("R7 edge held after release", req_valid[1], 1'b1);
    grant[1] = 1'b1;
    step(1);
    check("R7 R8 edge consumed", req_valid[1], 1'b0);
    grant[1] = 1'b0;
    step(3);
    check("R7 no new edge", req_valid[1], 1'b0);

    // R1: losing qualification discards a captured edge
    ext_pin[1] = 1'b0;
    step(3);
    check("R7 second edge", req_valid[1], 1'b1);
    ch_en[1] = 1'b0;
    step(1);
    check("R1 disable drops pending", req_valid[1], 1'b0);
    ch_en[1] = 1'b1;
    step(2);
    check("R1 pending stays dropped", req_valid[1], 1'b0);

    // R11: rising edge with high polarity
    ext_pol[1] = 1'b1;
    ext_pin[1] = 1'b0;
    step(4);
    grant[1] = 1'b1;
    step(1);
    grant[1] = 1'b0;
    step(1);
    check("R11 rising idle", req_valid[1], 1'b0);
    ext_pin[1] = 1'b1;
    step(3);
    check("R11 rising captured", req_valid[1], 1'b1);

    // R9: peripheral line follows with one cycle
    ch_sel[15:12] = 4'b1001;
    periph_req = 4'b0000;
    step(2);
    check("R9 periph low", req_valid[3], 1'b0);
    periph_req = 4'b0010;
    step(1);
    check("R9 periph follows", req_valid[3], 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule